// File: doc/BRIEF.md
# Dual Palette VGA Write Router

This block sits between the legacy VGA data port, a direct memory-mapped palette port and two palette RAMs, A and B. A legacy data-port write can land in A, B, both or neither, as two independent write-disable controls decide. On that legacy path only, data is converted between the 6-bit colour format old programs use and the 8-bit format held in the RAMs. The memory-mapped port always moves the raw 8-bit value and can reach either palette on its own.

The block also does the pixel lookup. Each pixel index comes with a plane flag: the normal plane looks up palette A and the popup plane looks up palette B. A test bypass sends the index straight to the colour output without any lookup. The VGA index register and its auto-increment logic sit outside this block, so the palette index arrives as an input. The RAM contents are not reset and must be loaded before they are read.

Top module: `vga_dual_pal_router`

## Requirements
- R1: A legacy access is recognised only when `io_addr` equals 16'h03C9. A write strobe at any other address leaves both palettes unchanged.
- R2: A recognised legacy write stores into palette A at `pal_index` only while `cfg_a_wr_dis` is 0. When that bit is 1, palette A keeps its old value.
- R3: Palette B follows `cfg_b_wr_dis` in the same way. With both bits at 0, one legacy write updates both palettes.
- R4: With both disable bits at 1, a legacy write changes no palette entry.
- R5: With `cfg_dac8` at 0, legacy write data is stored as `{wdata[5:0],2'b00}`, so its two top bits are lost. With `cfg_dac8` at 1, it is stored unchanged.
- R6: With `cfg_dac8` at 0, a legacy read returns the stored value shifted right by two, so bits [7:6] are 0. With `cfg_dac8` at 1, it returns the stored value unchanged.
- R7: A legacy read returns palette A at `pal_index` in `io_rdata` one cycle after the strobe. Otherwise `io_rdata` holds. If it coincides with a memory-mapped read of palette A (`mm_sel`=0), the legacy read is served and `mm_rdata` holds.
- R8: Memory-mapped writes and reads move data unshifted whatever `cfg_dac8` is. `mm_sel`=0 selects A and `mm_sel`=1 selects B. `mm_rdata` updates one cycle after `mm_rd` and holds otherwise.
- R9: When a memory-mapped write and a legacy write hit the same entry of the same palette in one cycle, the memory-mapped data is stored.
- R10: With `cfg_bypass` at 0, `pix_color` shows palette A at `pix_idx` when `pix_popup` is 0, or palette B when it is 1. It appears one cycle after the index.
- R11: With `cfg_bypass` at 1, `pix_color` equals `pix_idx`, zero-extended, one cycle later, on either plane.
- R12: During reset, `io_rdata`, `mm_rdata` and `pix_color` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_wr | input | 1 | Legacy I/O write strobe |
| io_rd | input | 1 | Legacy I/O read strobe |
| io_addr | input | 16 | Legacy I/O address |
| io_wdata | input | 8 | Legacy write data |
| pal_index | input | 8 | Palette entry for legacy accesses |
| io_rdata | output | 8 | Legacy read data, registered |
| mm_wr | input | 1 | Memory-mapped write strobe |
| mm_rd | input | 1 | Memory-mapped read strobe |
| mm_sel | input | 1 | Memory-mapped palette select (0 = A, 1 = B) |
| mm_addr | input | 8 | Memory-mapped palette entry |
| mm_wdata | input | 8 | Memory-mapped write data |
| mm_rdata | output | 8 | Memory-mapped read data, registered |
| cfg_a_wr_dis | input | 1 | Blocks legacy writes to palette A |
| cfg_b_wr_dis | input | 1 | Blocks legacy writes to palette B |
| cfg_dac8 | input | 1 | 1 = 8-bit legacy data, 0 = 6-bit |
| cfg_bypass | input | 1 | Pixel index passes to output without lookup |
| pix_idx | input | 8 | Pixel palette index |
| pix_popup | input | 1 | Pixel belongs to popup plane (uses palette B) |
| pix_color | output | 8 | Translated pixel colour, registered |

## Verification
The assertions check every cycle that the read outputs hold when no read is served, including a memory-mapped read that yields to a legacy read. They also check that 6-bit legacy reads never return anything in the top two bits, and that bypass puts the previous index on the colour output. Which palettes a legacy write reaches, the 6-bit write shift, the priority when both ports write one entry, and the plane-to-palette choice of the lookup all live in RAM contents. Only the bench can show these, by writing through one port and reading back through another.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
   localparam int unsigned NUM_BANKS    = 2;
   localparam int unsigned BANK_A       = 0;
   localparam int unsigned BANK_B       = 1;
   localparam logic [15:0] LEGACY_DPORT = 16'h03C9;
endpackage

// File: rtl/vpr_pal_bank.sv
module vpr_pal_bank #(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              leg_we,
   input  logic [IDX_W-1:0]  leg_addr,
   input  logic [DATA_W-1:0] leg_data,
   input  logic              mm_we,
   input  logic [IDX_W-1:0]  mm_addr,
   input  logic [DATA_W-1:0] mm_data,
   input  logic [IDX_W-1:0]  pix_addr,
   output logic [DATA_W-1:0] pix_q,
   input  logic [IDX_W-1:0]  host_addr,
   output logic [DATA_W-1:0] host_q
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // memory-mapped write is issued last so it wins on a shared entry
   always_ff @(posedge clk) begin
      if (leg_we) mem[leg_addr] <= leg_data;
      if (mm_we)  mem[mm_addr]  <= mm_data;
   end

   assign pix_q  = mem[pix_addr];
   assign host_q = mem[host_addr];
endmodule

// File: rtl/vpr_dac_shift.sv
module vpr_dac_shift #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SHIFT  = 2
) (
   input  logic              wide_mode,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] store_wdata,
   input  logic [DATA_W-1:0] store_rdata,
   output logic [DATA_W-1:0] host_rdata
);
   always_comb begin
      if (wide_mode) begin
         store_wdata = host_wdata;
         host_rdata  = store_rdata;
      end else begin
         store_wdata = host_wdata << SHIFT;
         host_rdata  = store_rdata >> SHIFT;
      end
   end
endmodule

// File: rtl/vpr_pix_stage.sv
module vpr_pix_stage #(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bypass,
   input  logic              popup,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] look_a,
   input  logic [DATA_W-1:0] look_b,
   output logic [DATA_W-1:0] color
);
   logic [DATA_W-1:0] color_d;

   always_comb begin
      if (bypass)     color_d = DATA_W'(idx);
      else if (popup) color_d = look_b;
      else            color_d = look_a;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) color <= '0;
      else        color <= color_d;
   end
endmodule

// File: rtl/vga_dual_pal_router.sv
module vga_dual_pal_router
   import vpr_pkg::*;
#(
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned IO_ADDR_W  = 16,
   parameter int unsigned DAC_SHIFT  = 2,
   parameter logic [15:0] DPORT_ADDR = LEGACY_DPORT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [IO_ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0]    io_wdata,
   input  logic [IDX_W-1:0]     pal_index,
   output logic [DATA_W-1:0]    io_rdata,
   input  logic                 mm_wr,
   input  logic                 mm_rd,
   input  logic                 mm_sel,
   input  logic [IDX_W-1:0]     mm_addr,
   input  logic [DATA_W-1:0]    mm_wdata,
   output logic [DATA_W-1:0]    mm_rdata,
   input  logic                 cfg_a_wr_dis,
   input  logic                 cfg_b_wr_dis,
   input  logic                 cfg_dac8,
   input  logic                 cfg_bypass,
   input  logic [IDX_W-1:0]     pix_idx,
   input  logic                 pix_popup,
   output logic [DATA_W-1:0]    pix_color
);
   generate
      if (DAC_SHIFT == 0 || DAC_SHIFT >= DATA_W) begin : g_bad_shift
         $error("DAC_SHIFT must lie between 1 and DATA_W-1");
      end
      if (IDX_W > DATA_W) begin : g_bad_idx
         $error("IDX_W must not exceed DATA_W for the bypass path");
      end
      if (IO_ADDR_W > 16) begin : g_bad_io
         $error("IO_ADDR_W must not exceed 16");
      end
   endgenerate

   logic                 leg_wr_hit;
   logic                 leg_rd_hit;
   logic                 mm_rd_served;
   logic [NUM_BANKS-1:0] wr_dis;
   logic [DATA_W-1:0]    leg_store;
   logic [DATA_W-1:0]    leg_host_rd;
   logic [DATA_W-1:0]    pix_q  [NUM_BANKS];
   logic [DATA_W-1:0]    host_q [NUM_BANKS];

   assign leg_wr_hit   = io_wr && (io_addr == DPORT_ADDR[IO_ADDR_W-1:0]);
   assign leg_rd_hit   = io_rd && (io_addr == DPORT_ADDR[IO_ADDR_W-1:0]);
   assign wr_dis       = {cfg_b_wr_dis, cfg_a_wr_dis};
   assign mm_rd_served = mm_rd && !(leg_rd_hit && (mm_sel == 1'(BANK_A)));

   vpr_dac_shift #(.DATA_W(DATA_W), .SHIFT(DAC_SHIFT)) i_dac (
      .wide_mode   (cfg_dac8),
      .host_wdata  (io_wdata),
      .store_wdata (leg_store),
      .store_rdata (host_q[BANK_A]),
      .host_rdata  (leg_host_rd)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [IDX_W-1:0] host_addr;
      if (b == BANK_A) begin : g_share
         assign host_addr = leg_rd_hit ? pal_index : mm_addr;
      end else begin : g_mm_only
         assign host_addr = mm_addr;
      end

      vpr_pal_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_bank (
         .clk       (clk),
         .leg_we    (leg_wr_hit && !wr_dis[b]),
         .leg_addr  (pal_index),
         .leg_data  (leg_store),
         .mm_we     (mm_wr && (mm_sel == 1'(b))),
         .mm_addr   (mm_addr),
         .mm_data   (mm_wdata),
         .pix_addr  (pix_idx),
         .pix_q     (pix_q[b]),
         .host_addr (host_addr),
         .host_q    (host_q[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_rdata <= '0;
         mm_rdata <= '0;
      end else begin
         if (leg_rd_hit)   io_rdata <= leg_host_rd;
         if (mm_rd_served) mm_rdata <= host_q[mm_sel];
      end
   end

   vpr_pix_stage #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_pix (
      .clk    (clk),
      .rst_n  (rst_n),
      .bypass (cfg_bypass),
      .popup  (pix_popup),
      .idx    (pix_idx),
      .look_a (pix_q[BANK_A]),
      .look_b (pix_q[BANK_B]),
      .color  (pix_color)
   );
endmodule

// File: rtl/vpr_checker.sv
module vpr_checker #(
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned IO_ADDR_W  = 16,
   parameter int unsigned DAC_SHIFT  = 2,
   parameter logic [15:0] DPORT_ADDR = 16'h03C9
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 io_rd,
   input logic [IO_ADDR_W-1:0] io_addr,
   input logic [DATA_W-1:0]    io_rdata,
   input logic                 mm_rd,
   input logic                 mm_sel,
   input logic [DATA_W-1:0]    mm_rdata,
   input logic                 cfg_dac8,
   input logic                 cfg_bypass,
   input logic [IDX_W-1:0]     pix_idx,
   input logic [DATA_W-1:0]    pix_color
);
   logic rd_hit;
   assign rd_hit = io_rd && (io_addr == DPORT_ADDR[IO_ADDR_W-1:0]);

   assert_io_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> $stable(io_rdata));

   assert_mm_yield_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && mm_rd && !mm_sel) |=> $stable(mm_rdata));

   assert_mm_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mm_rd |=> $stable(mm_rdata));

   assert_narrow_read_top_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !cfg_dac8) |=> (io_rdata[DATA_W-1 -: DAC_SHIFT] == '0));

   assert_bypass_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bypass |=> (pix_color == DATA_W'($past(pix_idx))));
endmodule

bind vga_dual_pal_router vpr_checker #(
   .IDX_W(IDX_W), .DATA_W(DATA_W), .IO_ADDR_W(IO_ADDR_W),
   .DAC_SHIFT(DAC_SHIFT), .DPORT_ADDR(DPORT_ADDR)
) i_vpr_checker (
   .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_addr(io_addr),
   .io_rdata(io_rdata), .mm_rd(mm_rd), .mm_sel(mm_sel), .mm_rdata(mm_rdata),
   .cfg_dac8(cfg_dac8), .cfg_bypass(cfg_bypass), .pix_idx(pix_idx),
   .pix_color(pix_color)
);

// File: tb/test_vga_dual_pal_router.sv
module test_vga_dual_pal_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 0, io_rd = 0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0, pal_index = '0;
   logic [7:0]  io_rdata;
   logic        mm_wr = 0, mm_rd = 0, mm_sel = 0;
   logic [7:0]  mm_addr = '0, mm_wdata = '0;
   logic [7:0]  mm_rdata;
   logic        cfg_a_wr_dis = 0, cfg_b_wr_dis = 0, cfg_dac8 = 0, cfg_bypass = 0;
   logic [7:0]  pix_idx = '0;
   logic        pix_popup = 0;
   logic [7:0]  pix_color;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   vga_dual_pal_router i_vga_dual_pal_router (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .pal_index(pal_index), .io_rdata(io_rdata),
      .mm_wr(mm_wr), .mm_rd(mm_rd), .mm_sel(mm_sel), .mm_addr(mm_addr),
      .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .cfg_a_wr_dis(cfg_a_wr_dis),
      .cfg_b_wr_dis(cfg_b_wr_dis), .cfg_dac8(cfg_dac8), .cfg_bypass(cfg_bypass),
      .pix_idx(pix_idx), .pix_popup(pix_popup), .pix_color(pix_color)
   );

   // row: {a_dis, b_dis, dac8, wdata, index, expect_A, expect_B}; both entries preset to 8'h11
   localparam logic [34:0] VEC [6] = '{
      {1'b0, 1'b0, 1'b0, 8'h3F, 8'h10, 8'hFC, 8'hFC},
      {1'b1, 1'b0, 1'b0, 8'hC5, 8'h20, 8'h11, 8'h14},
      {1'b0, 1'b1, 1'b1, 8'hC5, 8'h30, 8'hC5, 8'h11},
      {1'b1, 1'b1, 1'b1, 8'hAA, 8'h40, 8'h11, 8'h11},
      {1'b0, 1'b0, 1'b1, 8'h80, 8'hFF, 8'h80, 8'h80},
      {1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'hFC, 8'hFC}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic mm_write(input logic sel, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      mm_wr = 1; mm_sel = sel; mm_addr = a; mm_wdata = d;
      @(negedge clk);
      mm_wr = 0;
   endtask

   task automatic mm_read(input logic sel, input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      mm_rd = 1; mm_sel = sel; mm_addr = a;
      @(negedge clk);
      mm_rd = 0;
      d = mm_rdata;
   endtask

   task automatic io_write(input logic [15:0] ad, input logic [7:0] idx, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1; io_addr = ad; pal_index = idx; io_wdata = d;
      @(negedge clk);
      io_wr = 0;
   endtask

   task automatic io_read(input logic [7:0] idx, output logic [7:0] d);
      @(negedge clk);
      io_rd = 1; io_addr = 16'h03C9; pal_index = idx;
      @(negedge clk);
      io_rd = 0;
      d = io_rdata;
   endtask

   task automatic pix_look(input logic popup, input logic [7:0] idx, output logic [7:0] d);
      @(negedge clk);
      pix_popup = popup; pix_idx = idx;
      @(negedge clk);
      d = pix_color;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r, held;
      repeat (3) @(negedge clk);
      // R12: outputs cleared while reset is applied
      check("R12 io_rdata", io_rdata, 8'h00);
      check("R12 mm_rdata", mm_rdata, 8'h00);
      check("R12 pix_color", pix_color, 8'h00);
      rst_n = 1;

      // R2/R3/R4/R5: routing and write conversion
      for (int i = 0; i < 6; i++) begin
         mm_write(1'b0, VEC[i][23:16], 8'h11);
         mm_write(1'b1, VEC[i][23:16], 8'h11);
         @(negedge clk);
         cfg_a_wr_dis = VEC[i][34]; cfg_b_wr_dis = VEC[i][33]; cfg_dac8 = VEC[i][32];
         io_write(16'h03C9, VEC[i][23:16], VEC[i][31:24]);
         mm_read(1'b0, VEC[i][23:16], r);
         check($sformatf("R2/R4/R5 row %0d palette A", i), r, VEC[i][15:8]);
         mm_read(1'b1, VEC[i][23:16], r);
         check($sformatf("R3/R4/R5 row %0d palette B", i), r, VEC[i][7:0]);
      end
      cfg_a_wr_dis = 0; cfg_b_wr_dis = 0;

      // R1: other I/O address ignored (entry 0x10 holds FC in both)
      io_write(16'h03C8, 8'h10, 8'h55);
      mm_read(1'b0, 8'h10, r);
      check("R1 palette A untouched", r, 8'hFC);
      mm_read(1'b1, 8'h10, r);
      check("R1 palette B untouched", r, 8'hFC);

      // R6: read conversion
      cfg_dac8 = 0;
      io_read(8'h10, r);
      check("R6 6-bit read", r, 8'h3F);
      cfg_dac8 = 1;
      io_read(8'h10, r);
      check("R6 8-bit read", r, 8'hFC);

      // R8: mm path unshifted in 6-bit mode
      cfg_dac8 = 0;
      mm_write(1'b1, 8'h50, 8'hC3);
      mm_read(1'b1, 8'h50, r);
      check("R8 mm unshifted", r, 8'hC3);

      // R7: io_rdata holds without a read; legacy wins over mm read of A
      held = io_rdata;
      mm_read(1'b1, 8'h50, r);
      check("R7 io_rdata holds", io_rdata, held);
      cfg_dac8 = 1;
      held = mm_rdata;
      @(negedge clk);
      io_rd = 1; io_addr = 16'h03C9; pal_index = 8'h30;
      mm_rd = 1; mm_sel = 0; mm_addr = 8'h10;
      @(negedge clk);
      io_rd = 0; mm_rd = 0;
      check("R7 legacy read served", io_rdata, 8'hC5);
      check("R7 mm_rdata yields", mm_rdata, held);

      // R9: same entry written by both ports
      @(negedge clk);
      io_wr = 1; io_addr = 16'h03C9; pal_index = 8'h05; io_wdata = 8'h22;
      mm_wr = 1; mm_sel = 0; mm_addr = 8'h05; mm_wdata = 8'h77;
      @(negedge clk);
      io_wr = 0; mm_wr = 0;
      mm_read(1'b0, 8'h05, r);
      check("R9 mm write wins on A", r, 8'h77);
      mm_read(1'b1, 8'h05, r);
      check("R9 legacy still reaches B", r, 8'h22);

      // R10: lookup per plane (A[0x20]=11, B[0x20]=14)
      pix_look(1'b0, 8'h20, r);
      check("R10 main plane uses A", r, 8'h11);
      pix_look(1'b1, 8'h20, r);
      check("R10 popup plane uses B", r, 8'h14);

      // R11: bypass on both planes
      cfg_bypass = 1;
      pix_look(1'b0, 8'h20, r);
      check("R11 bypass main", r, 8'h20);
      pix_look(1'b1, 8'h5A, r);
      check("R11 bypass popup", r, 8'h5A);
      cfg_bypass = 0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule